// File: doc/BRIEF.md
# Sequential Signed Divider

This block divides one signed two's-complement word by another for an integer execution unit. A caller presents a dividend, a divisor, a record flag and the current summary-overflow bit, and pulses `start` while `busy` is low. For a legal divide the block works on the operand magnitudes with a restoring shift-subtract loop. It retires one quotient bit per clock and applies the sign once the loop is done. The quotient is truncated toward zero.

The two cases with no valid answer are caught when the operation is accepted and finish at once. These are a zero divisor, and the most negative value divided by minus one. Both return the most negative value as the quotient, along with a condition field that reads "less than". The summary-overflow bit is not forced in these cases. When the record flag is clear, the condition field is all zeros. `done` pulses for one cycle when `quot` and `cond` hold a new result. Both outputs then hold that result until the next one.

Top module: `sdiv_core`

## Requirements
- R1: A legal divide truncates toward zero, and `done` rises exactly W clock edges after the edge that accepted `start`.
- R2: A zero divisor gives the quotient with only bit W-1 set (0x80000000 for W=32), whatever the dividend.
- R3: A dividend of 0x80000000 with a divisor of all ones (-1) gives the quotient 0x80000000.
- R4: Both illegal cases raise `done` on the edge after acceptance, and `busy` never rises for them.
- R5: In an illegal case with `rec` set, `cond` reads LT=1, GT=0, EQ=0. Its SO bit equals `so_in` as sampled at acceptance. `cond` bit 3 is LT, bit 2 is GT, bit 1 is EQ and bit 0 is SO.
- R6: In a legal divide with `rec` set, LT is set for a negative quotient, GT for a positive one and EQ for zero, and SO equals the sampled `so_in`.
- R7: When `rec` was clear at acceptance, `cond` is 4'b0000 with the result.
- R8: A `start` pulse, and the operands with it, has no effect while `busy` is high. No extra `done` appears and the running result is unchanged.
- R9: `done` lasts one cycle per result and is never high while `busy` is high.
- R10: After reset, `busy`, `done`, `quot` and `cond` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a divide; taken only while `busy` is low |
| dividend | input | W | Signed numerator |
| divisor | input | W | Signed denominator |
| rec | input | 1 | Produce LT/GT/EQ/SO flags for this operation |
| so_in | input | 1 | Current summary-overflow bit |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle result-valid pulse |
| quot | output | W | Signed quotient |
| cond | output | 4 | {LT, GT, EQ, SO} condition field |

## Verification
The bench builds the block with the default W=32, which makes the full-width extreme values reachable. These include 0x80000000 divided by -1 and by 1, the largest positive value divided by -1, and dividends whose magnitude uses all 32 bits. A second build at a narrower width is left out. The 32-cycle latency stays short enough that a few hundred operands with random signs fit easily. Those operands are mixed with directed sign combinations and back-to-back illegal operations.

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         rec,
  input  logic         so_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [3:0]   cond
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  rem, qsh, dmag;
  logic          neg, rec_r, so_r;

  wire accept  = start & ~busy;
  wire illegal = (divisor == '0) | ((dividend == MINV) & (divisor == '1));

  wire [W-1:0] amag = dividend[W-1] ? -dividend : dividend;
  wire [W-1:0] bmag = divisor[W-1]  ? -divisor  : divisor;

  wire [W:0]   sh    = {rem, qsh[W-1]};
  wire [W:0]   diff  = sh - {1'b0, dmag};
  wire         fit   = ~diff[W];
  wire [W-1:0] rem_n = fit ? diff[W-1:0] : sh[W-1:0];
  wire [W-1:0] q_n   = {qsh[W-2:0], fit};
  wire [W-1:0] res   = neg ? -q_n : q_n;

  function automatic logic [3:0] flags(input logic [W-1:0] v, input logic r, input logic s);
    return r ? {v[W-1], ~v[W-1] & (|v), ~(|v), s} : 4'b0000;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      quot  <= '0;
      cond  <= '0;
      cnt   <= '0;
      rem   <= '0;
      qsh   <= '0;
      dmag  <= '0;
      neg   <= 1'b0;
      rec_r <= 1'b0;
      so_r  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (illegal) begin
          quot <= MINV;
          cond <= rec ? {3'b100, so_in} : 4'b0000;
          done <= 1'b1;
        end else begin
          busy  <= 1'b1;
          cnt   <= '0;
          rem   <= '0;
          qsh   <= amag;
          dmag  <= bmag;
          neg   <= dividend[W-1] ^ divisor[W-1];
          rec_r <= rec;
          so_r  <= so_in;
        end
      end else if (busy) begin
        rem <= rem_n;
        qsh <= q_n;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          quot <= res;
          cond <= flags(res, rec_r, so_r);
        end
      end
    end
  end
endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         rec,
  input logic         so_in,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quot,
  input logic [3:0]   cond
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  wire acc = start && !busy;
  wire bad = (divisor == '0) || ((dividend == MINV) && (divisor == '1));

  int   lat;
  logic rec_q, ill_q, so_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= 0; rec_q <= 1'b0; ill_q <= 1'b0; so_q <= 1'b0;
    end else if (acc) begin
      lat <= 0; rec_q <= rec; ill_q <= bad; so_q <= so_in;
    end else if (busy) begin
      lat <= lat + 1;
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ill_q |-> lat == W);
  p_div_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && divisor == '0 |=> done && quot == MINV);
  p_min_neg1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && dividend == MINV && divisor == '1 |=> done && quot == MINV);
  p_fast_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bad |=> done && !busy);
  p_ill_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bad && rec |=> cond == {3'b100, $past(so_in)});
  p_sign_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && rec_q && !ill_q |-> cond == {quot[W-1], !quot[W-1] && quot != '0, quot == '0, so_q});
  p_no_rec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !rec_q |-> cond == 4'b0000);
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> busy || done);
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind sdiv_core sdiv_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
  .rec(rec), .so_in(so_in), .busy(busy), .done(done), .quot(quot), .cond(cond)
);

// File: tb/sdiv_core_tb.sv
module sdiv_core_tb;
  localparam int W = 32;
  localparam logic [W-1:0] MINV = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rec = 1'b0, so_in = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done;
  logic [W-1:0] quot;
  logic [3:0] cond;

  sdiv_core #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .rec(rec), .so_in(so_in), .busy(busy), .done(done), .quot(quot), .cond(cond)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [W-1:0] q;
    logic [3:0]   c;
    int           lat;
    int           t0;
    string        tag;
  } item_t;

  item_t sb[$];
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic r, input logic s);
    item_t it;
    logic signed [W-1:0] sa, sb_, sq;
    sa = a; sb_ = b;
    @(negedge clk);
    while (busy) @(negedge clk);
    if (b == '0) begin
      it.q = MINV; it.lat = 0; it.tag = "R2";
    end else if (a == MINV && b == '1) begin
      it.q = MINV; it.lat = 0; it.tag = "R3";
    end else begin
      sq = sa / sb_;
      it.q = sq; it.lat = W; it.tag = "R1";
    end
    if (!r) it.c = 4'b0000;
    else if (it.lat == 0) it.c = {3'b100, s};
    else it.c = {it.q[W-1], !it.q[W-1] && it.q != '0, it.q == '0, s};
    it.t0 = cyc + 1;
    sb.push_back(it);
    dividend = a; divisor = b; rec = r; so_in = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dividend = $urandom; divisor = $urandom;
  endtask

  task automatic poke_busy();
    @(negedge clk);
    while (!busy) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      dividend = 32'h0000_0007; divisor = '0; rec = 1'b1; so_in = 1'b1; start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R8 done with no accepted request", quot, '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(quot == it.q, {it.tag, " quotient"}, quot, it.q);
        chk(cond == it.c, (it.lat == 0) ? "R5/R7 cond" : "R6/R7 cond", W'(cond), W'(it.c));
        chk(cyc - it.t0 == it.lat, (it.lat == 0) ? "R4 latency" : "R1 latency", W'(cyc - it.t0), W'(it.lat));
        chk(!busy, "R9 busy with done", W'(busy), '0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && quot == '0 && cond == 4'b0, "R10 reset state",
        {busy, done, quot[W-3:0]}, '0);
    rst_n = 1'b1;
    issue(7, 2, 1, 0);
    issue(-7, 2, 1, 1);
    issue(7, -2, 1, 0);
    issue(-7, -2, 1, 0);
    issue(0, 5, 1, 1);
    issue(3, 9, 1, 0);
    issue(MINV, 1, 1, 0);
    issue(MINV, 2, 0, 1);
    issue(32'h7FFF_FFFF, '1, 1, 0);
    issue(MINV, MINV, 1, 1);
    issue(1, 32'h7FFF_FFFF, 1, 0);
    issue(12345, 0, 1, 1);
    issue(0, 0, 1, 0);
    issue(-5, 0, 0, 1);
    issue(MINV, '1, 1, 1);
    issue(MINV, '1, 1, 0);
    issue(MINV, '1, 0, 1);
    fork
      issue(32'h1234_5678, 3, 1, 0);
      poke_busy();
    join
    for (int i = 0; i < 250; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 4 == 1) b = $urandom_range(0, 16) - 8;
      if (i % 7 == 3) a = a >> $urandom_range(0, 31);
      issue(a, b, $urandom_range(0, 1), $urandom_range(0, 1));
    end
    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R8 leftover results", W'(sb.size()), '0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule